// File: doc/BRIEF.md
# Shared Serial Output Slot Controller

This block lets up to eight converter instances share one serial data line by taking turns. Each instance has a fixed 3-bit bus address and a 3-bit share value, set to the number of instances on the bus minus one. A data-ready strobe starts a frame. From that strobe, every instance counts rising edges of the serial clock. The frame is split into 32-edge slots in address order. An instance drives its captured conversion result, MSB first, only inside its own slot. The rest of the time it presents high impedance, which this block reports through an output-enable signal.

Within a slot, the instance drives for the first 30 clocks only. It releases the line before the slot ends, so two instances never drive at the same time. Each instance also gives an active-low frame-sync pulse on the first clock of its own slot. Counting stops when the last slot of the frame has passed. If the address exceeds the share value, the instance stays silent and flags a configuration error.

Top module: `shared_sdo_slot_ctrl`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `fso_no` is 1 and `sdo_o` is 0 until a data-ready strobe is sampled.
- R2: The instance at address 0 asserts `sdo_oe_o` on the first rising edge after the edge that samples `drdy_i` high.
- R3: The instance at address k first asserts `sdo_oe_o` on rising edge 32·k+1, counted from the data-ready edge (edge 0).
- R4: `sdo_oe_o` stays high for exactly 30 clocks and drops on edge 32·k+31. This leaves the line undriven until the next slot begins.
- R5: At slot position p (0..29), `sdo_o` carries bit 31−p of the 32-bit result captured at the data-ready edge. `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R6: `fso_no` is low for exactly one clock, the one that follows edge 32·k+1. It is high at all other times.
- R7: Counting stops after (share+1)·32 edges. After that, outputs stay quiet until the next data-ready strobe.
- R8: A data-ready strobe in the middle of a frame restarts the edge count at 0, and the slot timing runs again from that strobe.
- R9: When address > share, `cfg_err_o` is 1 and `sdo_oe_o` and `fso_no` never become active.
- R10: Changes on `data_i` after the data-ready edge have no effect on the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; all counting on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drdy_i | input | 1 | Data-ready strobe, active high, one clock wide |
| addr_i | input | 3 | Static bus address of this instance |
| share_i | input | 3 | Number of instances on the bus minus one |
| data_i | input | 32 | Conversion result, captured on the data-ready edge |
| sdo_o | output | 1 | Serial data bit, valid when enabled |
| sdo_oe_o | output | 1 | Output enable; low means high impedance |
| fso_no | output | 1 | Active-low frame sync for this instance's slot |
| cfg_err_o | output | 1 | Address greater than share value |

## Verification
The bench builds the block with its default parameters: 3-bit address and share, 32-clock slots, 30 driven clocks, and a 32-bit result shifted MSB first. These values allow slot starts up to edge 225 at address 7 with share 7, as well as the smallest frame, share 0. The bench also steps through the two-clock quiet gap between slots and through the end of the frame, after which the block must stay idle. A restart in the middle of a frame and a mismatched address are both reachable at these sizes.

// File: rtl/shared_sdo_slot_pkg.sv
package shared_sdo_slot_pkg;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned SLOT_LEN = 32;
  localparam int unsigned DRIVE_N  = 30;
  localparam int unsigned RES_W    = 32;

  typedef enum logic {ORDER_MSB_FIRST = 1'b0, ORDER_LSB_FIRST = 1'b1} bit_order_e;
endpackage

// File: rtl/ssc_edge_counter.sv
module ssc_edge_counter #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SLOT_LG = 5,
  localparam int unsigned CNT_W  = ADDR_W + SLOT_LG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] share_i,
  output logic [CNT_W-1:0]  edge_o,
  output logic              active_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;
  logic [CNT_W-1:0] limit;

  // last counted edge of the frame: (share+1) slots
  assign limit = ({{(CNT_W-ADDR_W){1'b0}}, share_i} + CNT_W'(1)) << SLOT_LG;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == limit) act_q <= 1'b0;
      else                cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign edge_o   = cnt_q;
  assign active_o = act_q;
endmodule

// File: rtl/ssc_slot_decode.sv
module ssc_slot_decode #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SLOT_LG = 5,
  parameter int unsigned DRIVE_N = 30,
  localparam int unsigned CNT_W  = ADDR_W + SLOT_LG + 1
) (
  input  logic [CNT_W-1:0]   edge_i,
  input  logic               active_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               cfg_err_i,
  output logic               drive_o,
  output logic               sync_o,
  output logic [SLOT_LG-1:0] pos_o
);
  logic [CNT_W-1:0]   idx;
  logic [ADDR_W:0]    slot;
  logic [SLOT_LG-1:0] pos;
  logic               mine;

  // edge n belongs to slot (n-1)/32, position (n-1)%32
  assign idx  = edge_i - CNT_W'(1);
  assign slot = idx[SLOT_LG +: ADDR_W+1];
  assign pos  = idx[SLOT_LG-1:0];
  assign mine = active_i && (edge_i != '0) && (slot == {1'b0, addr_i}) && !cfg_err_i;

  assign drive_o = mine && (pos < SLOT_LG'(DRIVE_N));
  assign sync_o  = mine && (pos == '0);
  assign pos_o   = pos;
endmodule

// File: rtl/ssc_result_hold.sv
module ssc_result_hold
  import shared_sdo_slot_pkg::*;
#(
  parameter int unsigned RES_W   = 32,
  parameter int unsigned SLOT_LG = 5,
  parameter bit_order_e  ORDER   = ORDER_MSB_FIRST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [RES_W-1:0]   data_i,
  input  logic               drive_i,
  input  logic [SLOT_LG-1:0] pos_i,
  output logic               bit_o
);
  logic [RES_W-1:0] res_q;
  logic             sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= data_i;
  end

  generate
    if (ORDER == ORDER_MSB_FIRST) begin : g_msb
      assign sel = res_q[RES_W-1-int'(pos_i)];
    end else begin : g_lsb
      assign sel = res_q[pos_i];
    end
  endgenerate

  assign bit_o = drive_i & sel;
endmodule

// File: rtl/shared_sdo_slot_ctrl.sv
module shared_sdo_slot_ctrl
  import shared_sdo_slot_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned SLOT_CLKS = SLOT_LEN,
  parameter int unsigned DRIVE_CLKS = DRIVE_N,
  parameter int unsigned DATA_BITS = RES_W,
  localparam int unsigned SLOT_LG  = $clog2(SLOT_CLKS),
  localparam int unsigned CNT_W    = ADDR_BITS + SLOT_LG + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 drdy_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [ADDR_BITS-1:0] share_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 sdo_o,
  output logic                 sdo_oe_o,
  output logic                 fso_no,
  output logic                 cfg_err_o
);
  logic [CNT_W-1:0]   edge_cnt;
  logic               active;
  logic               drive;
  logic               sync;
  logic [SLOT_LG-1:0] pos;

  assign cfg_err_o = addr_i > share_i;

  ssc_edge_counter #(.ADDR_W(ADDR_BITS), .SLOT_LG(SLOT_LG)) u_cnt (
    .clk_i, .rst_ni, .start_i(drdy_i), .share_i,
    .edge_o(edge_cnt), .active_o(active)
  );

  ssc_slot_decode #(.ADDR_W(ADDR_BITS), .SLOT_LG(SLOT_LG), .DRIVE_N(DRIVE_CLKS)) u_dec (
    .edge_i(edge_cnt), .active_i(active), .addr_i, .cfg_err_i(cfg_err_o),
    .drive_o(drive), .sync_o(sync), .pos_o(pos)
  );

  ssc_result_hold #(.RES_W(DATA_BITS), .SLOT_LG(SLOT_LG), .ORDER(ORDER_MSB_FIRST)) u_res (
    .clk_i, .rst_ni, .load_i(drdy_i), .data_i,
    .drive_i(drive), .pos_i(pos), .bit_o(sdo_o)
  );

  assign sdo_oe_o = drive;
  assign fso_no   = ~sync;
endmodule

// File: rtl/shared_sdo_slot_ctrl_chk.sv
module shared_sdo_slot_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic drdy_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic fso_no,
  input logic cfg_err_o
);
  AST_CFG_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!sdo_oe_o && fso_no)); // R9
  AST_SYNC_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fso_no |-> sdo_oe_o); // R6
  AST_SYNC_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fso_no |=> fso_no); // R6
  AST_OE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> !fso_no); // R3
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_i |=> (!sdo_oe_o && fso_no)); // R8
  AST_SDO_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o); // R5
endmodule

bind shared_sdo_slot_ctrl shared_sdo_slot_ctrl_chk u_chk (
  .clk_i, .rst_ni, .drdy_i, .sdo_o, .sdo_oe_o, .fso_no, .cfg_err_o
);

// File: tb/shared_sdo_slot_ctrl_bench.sv
module shared_sdo_slot_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        drdy_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [2:0]  share_i = '0;
  logic [31:0] data_i = '0;
  logic        sdo_o, sdo_oe_o, fso_no, cfg_err_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  shared_sdo_slot_ctrl u_shared_sdo_slot_ctrl (.*);

  task automatic chk(input string req, input int n, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: {err,oe,fso_n,sdo} actual %b expected %b", req, n, act, exp);
    end
  endtask

  // expected outputs for edge n after data-ready (edge 0)
  function automatic logic [3:0] expect_at(int n, int a, int s, logic [31:0] d);
    logic err, oe, fs, bo;
    int slot, pos;
    err = (a > s);
    oe = 1'b0; fs = 1'b1; bo = 1'b0;
    if (!err && n >= 1 && n <= (s + 1) * 32) begin
      slot = (n - 1) / 32;
      pos  = (n - 1) % 32;
      if (slot == a && pos < 30) begin
        oe = 1'b1;
        bo = d[31 - pos];
        fs = (pos != 0);
      end
    end
    return {err, oe, fs, bo};
  endfunction

  // at a negedge: strobe data-ready with new data, then scramble data_i (R10)
  task automatic strobe(input logic [31:0] d);
    drdy_i = 1'b1;
    data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    drdy_i = 1'b0;
    data_i = ~d ^ 32'h5A5A_A5A5;
  endtask

  task automatic watch(input string req, input int a, input int s, input logic [31:0] d,
                       input int last_n);
    chk(req, 0, {cfg_err_o, sdo_oe_o, fso_no, sdo_o}, expect_at(0, a, s, d));
    for (int n = 1; n <= last_n; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(req, n, {cfg_err_o, sdo_oe_o, fso_no, sdo_o}, expect_at(n, a, s, d));
    end
  endtask

  task automatic run_frame(input string req, input int a, input int s, input logic [31:0] d);
    @(negedge clk_i);
    addr_i  = 3'(a);
    share_i = 3'(s);
    strobe(d);
    watch(req, a, s, d, (s + 1) * 32 + 6);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1", 0, {cfg_err_o, sdo_oe_o, fso_no, sdo_o}, 4'b0010);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R1", i, {cfg_err_o, sdo_oe_o, fso_no, sdo_o}, 4'b0010);
    end
  endtask

  task automatic t_restart;
    logic [31:0] d2;
    d2 = 32'hC3A5_0F96;
    @(negedge clk_i);
    addr_i  = 3'd1;
    share_i = 3'd2;
    strobe(32'h1234_5678);
    watch("R8", 1, 2, 32'h1234_5678, 40);
    strobe(d2);
    watch("R8", 1, 2, d2, 3 * 32 + 4);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();                                    // R1
    run_frame("R2", 0, 3, 32'hB6D1_9E3F);         // R2 R4 R5 R6
    run_frame("R3", 3, 3, 32'h8000_0003);         // R3 last slot of four
    run_frame("R4", 2, 7, 32'hFFFF_FFFF);         // R4 gap and R10 scramble
    run_frame("R7", 7, 7, 32'h5555_AAAA);         // R7 end of longest frame
    run_frame("R7", 0, 0, 32'hA0F0_0F0D);         // R7 single instance
    run_frame("R5", 1, 1, 32'h0123_4567);         // R5 R10
    run_frame("R9", 5, 3, 32'hFFFF_FFFF);         // R9 mismatched address
    t_restart();                                  // R8
    // R10: data_i held at a different value than captured must not leak
    run_frame("R10", 0, 1, 32'h0F0F_F0F0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule